// File: doc/BRIEF.md
# Remote Diode Polarity Address Detector

This block works out, after power-on and again after every software reset, which of the two pins of each remote sense pair is the positive (anode) terminal. It probes one pair at a time and takes at most two steps per pair. In each step it forces current into one pin and biases the other pin of the same pair to roughly 0.6 V. It waits a programmable settling time, then reads a comparator that reports whether the forced pin has pulled up close to the supply.

A forced pin that stays low is taken to be the positive terminal. Each pair's orientation drives two things: the channel pin mapping used by the converter, and one low bit of the device's two-wire address. The upper address bits are fixed.

The bus interface treats the address as valid only once the done flag is high. It must not acknowledge any address before then. The analog current sources, bias drivers and comparators sit outside this block.

Top module: `diode_orient_probe`

## Requirements
- R1: While `rst` is high, and from the clock edge that samples `restart` high, `done`, `dxp_sel`, `addr_suffix`, `force_cur` and `bias_sel` are all zero. A new detection pass then begins.
- R2: Step one of pair k forces current into pin 2k only and biases pin 2k+1 only. If `near_supply[2k]` reads 0, the pair resolves with `dxp_sel[k]`=0 and no step two is taken.
- R3: If step one reads 1, step two forces pin 2k+1 only and biases pin 2k only. If `near_supply[2k+1]` then reads 0, `dxp_sel[k]`=1.
- R4: If both pins read 1 (open pair), the pair resolves to `dxp_sel[k]`=0. If both read 0 (shorted pair), it also resolves to `dxp_sel[k]`=0, through R2.
- R5: The comparator is sampled only after the pin has been forced for SETTLE_CYC clock cycles. Each probe step lasts exactly SETTLE_CYC cycles.
- R6: Pair 0 is fully resolved before any pin of pair 1 is forced. `addr_suffix` bit 1 equals `dxp_sel[0]`, and bit 0 equals `dxp_sel[1]`. In general, pair k sets bit NUM_PAIRS-1-k.
- R7: `dev_addr` is the fixed prefix 10011 followed by `addr_suffix`, giving 0x4C to 0x4F.
- R8: At most one pin is forced at any time. No pin is ever forced and biased together. No pin is forced or biased while `done` is high.
- R9: Once high, `done` stays high, and `dxp_sel` and `addr_suffix` hold their values, until `rst` or `restart`. Comparator activity has no effect on them.
- R10: `done` rises exactly 1 + (total probe steps × SETTLE_CYC) cycles after the edge that sampled the reset or restart. It never rises before the last pair has been resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| restart | input | 1 | Software-reset request; restarts detection |
| near_supply | input | 2*NUM_PAIRS | Per-pin comparator: forced pin is near supply |
| force_cur | output | 2*NUM_PAIRS | Per-pin current-force enable |
| bias_sel | output | 2*NUM_PAIRS | Per-pin 0.6 V bias enable |
| dxp_sel | output | NUM_PAIRS | Per pair: 0 = first pin positive, 1 = second pin positive |
| addr_suffix | output | NUM_PAIRS | Low address bits derived from the orientations |
| dev_addr | output | ADDR_W | Full 7-bit device address |
| done | output | 1 | Detection complete; address valid |

## Verification
The bench builds the block with NUM_PAIRS=2 and SETTLE_CYC=6. With these values a full pass takes at most 25 cycles, so every combination of orientations, open pairs and shorted pairs runs in a short bench. The comparator model reports the inverted result until a pin has been forced for six cycles. Sampling even one cycle early therefore gives the wrong orientation. The short pass also makes it cheap to check the exact cycle of `done`, and to restart detection in the middle of a step.

// File: rtl/orient_pkg.sv
package orient_pkg;
  typedef enum logic [1:0] {
    PH_START   = 2'd0,
    PH_PROBE_A = 2'd1,
    PH_PROBE_B = 2'd2,
    PH_DONE    = 2'd3
  } probe_phase_t;
endpackage

// File: rtl/orient_settle_timer.sv
module orient_settle_timer #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic clear_i,
  output logic expired_o
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clear_i)
      cnt_q <= '0;
    else if (cnt_q != LAST)
      cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/orient_pin_drive.sv
module orient_pin_drive
  import orient_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int PW = 1
) (
  input  logic                     clk,
  input  logic                     clr_i,
  input  probe_phase_t             phase_n_i,
  input  logic [PW-1:0]            pair_n_i,
  output logic [2*NUM_PAIRS-1:0]   force_o,
  output logic [2*NUM_PAIRS-1:0]   bias_o
);
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic sel_here;
    assign sel_here = (pair_n_i == PW'(k));

    always_ff @(posedge clk) begin
      if (clr_i) begin
        force_o[2*k]   <= 1'b0;
        force_o[2*k+1] <= 1'b0;
        bias_o[2*k]    <= 1'b0;
        bias_o[2*k+1]  <= 1'b0;
      end else begin
        // first pin forced, partner biased during step one
        force_o[2*k]   <= sel_here && (phase_n_i == PH_PROBE_A);
        bias_o[2*k+1]  <= sel_here && (phase_n_i == PH_PROBE_A);
        // roles swap during step two
        force_o[2*k+1] <= sel_here && (phase_n_i == PH_PROBE_B);
        bias_o[2*k]    <= sel_here && (phase_n_i == PH_PROBE_B);
      end
    end
  end

  AST_ONE_PIN_FORCED: assert property (@(posedge clk) disable iff (clr_i)
    $onehot0(force_o)); // R8
  AST_FORCE_BIAS_APART: assert property (@(posedge clk) disable iff (clr_i)
    (force_o & bias_o) == '0); // R8
  AST_ONE_PIN_BIASED: assert property (@(posedge clk) disable iff (clr_i)
    $countones(bias_o) == $countones(force_o)); // R2
endmodule

// File: rtl/orient_result_bank.sv
module orient_result_bank #(
  parameter int NUM_PAIRS = 2
) (
  input  logic                 clk,
  input  logic                 clr_i,
  input  logic [NUM_PAIRS-1:0] load_i,
  input  logic                 value_i,
  output logic [NUM_PAIRS-1:0] dxp_o,
  output logic [NUM_PAIRS-1:0] suffix_o
);
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (clr_i)
        dxp_o[k] <= 1'b0;
      else if (load_i[k])
        dxp_o[k] <= value_i;
    end
    // earliest pair lands in the most significant suffix bit
    assign suffix_o[NUM_PAIRS-1-k] = dxp_o[k];
  end

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (clr_i)
    $onehot0(load_i)); // R6
endmodule

// File: rtl/diode_orient_probe.sv
module diode_orient_probe
  import orient_pkg::*;
#(
  parameter int NUM_PAIRS  = 2,
  parameter int SETTLE_CYC = 1000,
  parameter int ADDR_W     = 7,
  parameter logic [ADDR_W-NUM_PAIRS-1:0] ADDR_PREFIX = 'b10011
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   restart,
  input  logic [2*NUM_PAIRS-1:0] near_supply,
  output logic [2*NUM_PAIRS-1:0] force_cur,
  output logic [2*NUM_PAIRS-1:0] bias_sel,
  output logic [NUM_PAIRS-1:0]   dxp_sel,
  output logic [NUM_PAIRS-1:0]   addr_suffix,
  output logic [ADDR_W-1:0]      dev_addr,
  output logic                   done
);
  localparam int HOLD = (SETTLE_CYC < 2) ? 2 : SETTLE_CYC;
  localparam int PW   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam logic [PW-1:0] LAST_PAIR = PW'(NUM_PAIRS - 1);

  logic                 clr;
  probe_phase_t         phase_q, phase_n;
  logic [PW-1:0]        pair_q, pair_n;
  logic                 step_load;
  logic                 expired;
  logic [NUM_PAIRS-1:0] load_vec;
  logic                 load_val;
  logic                 sampling;
  logic [1:0]           near_pair [NUM_PAIRS];

  assign clr = rst | restart;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_near
    assign near_pair[k] = near_supply[2*k+1:2*k];
  end

  orient_settle_timer #(.HOLD_CYC(HOLD)) u_timer (
    .clk       (clk),
    .clear_i   (clr | step_load),
    .expired_o (expired)
  );

  always_comb begin
    phase_n   = phase_q;
    pair_n    = pair_q;
    step_load = 1'b0;
    load_vec  = '0;
    load_val  = 1'b0;
    unique case (phase_q)
      PH_START: begin
        phase_n   = PH_PROBE_A;
        pair_n    = '0;
        step_load = 1'b1;
      end
      PH_PROBE_A: begin
        if (expired) begin
          if (!near_pair[pair_q][0]) begin
            load_vec[pair_q] = 1'b1;
            load_val         = 1'b0;
            if (pair_q == LAST_PAIR) begin
              phase_n = PH_DONE;
            end else begin
              pair_n    = pair_q + PW'(1);
              phase_n   = PH_PROBE_A;
              step_load = 1'b1;
            end
          end else begin
            phase_n   = PH_PROBE_B;
            step_load = 1'b1;
          end
        end
      end
      PH_PROBE_B: begin
        if (expired) begin
          load_vec[pair_q] = 1'b1;
          // second pin still low means it is the anode; open pair falls back
          load_val         = !near_pair[pair_q][1];
          if (pair_q == LAST_PAIR) begin
            phase_n = PH_DONE;
          end else begin
            pair_n    = pair_q + PW'(1);
            phase_n   = PH_PROBE_A;
            step_load = 1'b1;
          end
        end
      end
      PH_DONE: begin
        phase_n = PH_DONE;
      end
      default: phase_n = PH_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q <= PH_START;
      pair_q  <= '0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      pair_q  <= pair_n;
      done    <= (phase_n == PH_DONE);
    end
  end

  orient_pin_drive #(.NUM_PAIRS(NUM_PAIRS), .PW(PW)) u_drive (
    .clk       (clk),
    .clr_i     (clr),
    .phase_n_i (phase_n),
    .pair_n_i  (pair_n),
    .force_o   (force_cur),
    .bias_o    (bias_sel)
  );

  orient_result_bank #(.NUM_PAIRS(NUM_PAIRS)) u_bank (
    .clk      (clk),
    .clr_i    (clr),
    .load_i   (load_vec),
    .value_i  (load_val),
    .dxp_o    (dxp_sel),
    .suffix_o (addr_suffix)
  );

  assign dev_addr = {ADDR_PREFIX, addr_suffix};

  assign sampling = expired && ((phase_q == PH_PROBE_A) || (phase_q == PH_PROBE_B));

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!done && force_cur == '0 && bias_sel == '0 && addr_suffix == '0)); // R1
  AST_SAMPLE_AFTER_HOLD: assert property (@(posedge clk) disable iff (clr)
    sampling |-> (force_cur != '0 && $stable(force_cur))); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (clr)
    done |=> (done && $stable(addr_suffix) && $stable(dxp_sel))); // R9
  AST_DONE_PINS_IDLE: assert property (@(posedge clk) disable iff (clr)
    done |-> (force_cur == '0 && bias_sel == '0)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (clr)
    $rose(done) |-> (pair_q == LAST_PAIR)); // R10
endmodule

// File: tb/sim_diode_orient_probe.sv
`timescale 1ns/1ps
module sim_diode_orient_probe;
  localparam int NP = 2;
  localparam int S  = 6;
  localparam logic [1:0] C_APOS = 2'd0, C_BPOS = 2'd1, C_OPEN = 2'd2, C_SHORT = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic [2*NP-1:0] near_supply;
  logic [2*NP-1:0] force_cur, bias_sel;
  logic [NP-1:0]   dxp_sel, addr_suffix;
  logic [6:0]      dev_addr;
  logic            done;

  logic [1:0] cfg [NP];
  int hold [2*NP];
  int checks = 0, fails = 0, wd = 0;
  int viol_drive = 0, viol_order = 0, max_pair = 0;

  always #4 clk = ~clk;

  diode_orient_probe #(.NUM_PAIRS(NP), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst(rst), .restart(restart), .near_supply(near_supply),
    .force_cur(force_cur), .bias_sel(bias_sel), .dxp_sel(dxp_sel),
    .addr_suffix(addr_suffix), .dev_addr(dev_addr), .done(done)
  );

  function automatic logic pin_rises(logic [1:0] c, bit second);
    case (c)
      C_APOS:  return second;
      C_BPOS:  return !second;
      C_OPEN:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // analog model: wrong answer until the pin has been forced for S cycles
  always_comb begin
    for (int p = 0; p < 2*NP; p++) begin
      logic t;
      t = bias_sel[p^1] ? pin_rises(cfg[p/2], p[0]) : 1'b1;
      near_supply[p] = force_cur[p] ? ((hold[p] >= S) ? t : !t) : 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2*NP; p++)
      hold[p] <= force_cur[p] ? hold[p] + 1 : 0;
    if (rst || restart) begin
      max_pair <= 0;
    end else if (force_cur != '0) begin
      for (int p = 0; p < 2*NP; p++) begin
        if (force_cur[p]) begin
          if (bias_sel != ((2*NP)'(1) << (p^1))) viol_drive <= viol_drive + 1;
          if (p/2 < max_pair) viol_order <= viol_order + 1;
          else max_pair <= p/2;
        end
      end
      if (!$onehot(force_cur)) viol_drive <= viol_drive + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected=<100000", wd);
      finish_run();
    end
  end

  // pulse reset or restart, then measure detection and results
  task automatic run_case(input logic [1:0] c0, input logic [1:0] c1, input bit use_rst,
                          input logic [1:0] exp_dxp, input int steps, input string tag);
    int cyc, vd, vo;
    logic [1:0] sfx;
    cfg[0] = c0; cfg[1] = c1;
    @(negedge clk);
    if (use_rst) rst = 1'b1; else restart = 1'b1;
    vd = viol_drive; vo = viol_order;
    @(negedge clk);
    rst = 1'b0; restart = 1'b0;
    check({"R1 quiet after restart ", tag}, {done, force_cur, bias_sel, dxp_sel}, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check({"R5 R10 done cycle ", tag}, cyc, 1 + steps*S);
    check({"R2 R3 R4 dxp_sel ", tag}, dxp_sel, exp_dxp);
    sfx = {exp_dxp[0], exp_dxp[1]};
    check({"R6 addr_suffix ", tag}, addr_suffix, sfx);
    check({"R7 dev_addr ", tag}, dev_addr, {5'b10011, sfx});
    check({"R8 drive pattern ", tag}, viol_drive - vd, 0);
    check({"R6 pair order ", tag}, viol_order - vo, 0);
  endtask

  task automatic t_reset_state();
    cfg[0] = C_APOS; cfg[1] = C_APOS;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {done, force_cur, bias_sel, dxp_sel, addr_suffix}, 0);
  endtask

  task automatic t_hold_after_done();
    logic [1:0] d0;
    d0 = dxp_sel;
    cfg[0] = C_OPEN; cfg[1] = C_SHORT;
    repeat (20) @(negedge clk);
    check("R9 done held", done, 1);
    check("R9 dxp unchanged", dxp_sel, d0);
    check("R8 pins idle when done", {force_cur, bias_sel}, 0);
  endtask

  task automatic t_mid_restart();
    cfg[0] = C_BPOS; cfg[1] = C_BPOS;
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    repeat (S + 3) @(negedge clk);
    check("R1 probing underway before restart", force_cur != 0, 1);
    run_case(C_APOS, C_BPOS, 1'b0, 2'b10, 3, "mid-restart");
  endtask

  initial begin
    t_reset_state();
    run_case(C_APOS, C_APOS, 1'b1, 2'b00, 2, "power-on a/a");
    run_case(C_APOS, C_BPOS, 1'b0, 2'b10, 3, "a/b");
    run_case(C_BPOS, C_APOS, 1'b0, 2'b01, 3, "b/a");
    run_case(C_BPOS, C_BPOS, 1'b0, 2'b11, 4, "b/b");
    t_hold_after_done();
    run_case(C_OPEN, C_SHORT, 1'b0, 2'b00, 3, "open/short");
    run_case(C_SHORT, C_OPEN, 1'b0, 2'b00, 3, "short/open");
    t_mid_restart();
    run_case(C_BPOS, C_OPEN, 1'b1, 2'b01, 4, "reset b/open");
    finish_run();
  end
endmodule